// File: doc/BRIEF.md
# Indirect Byte Store Port with Auto-Advance

This block holds a 256-byte user memory that is not mapped directly into the register space. Software reaches it through two registers. One register holds a byte pointer. The other is a data window that reads or writes the byte the pointer selects. A third register holds a single mode bit. When that bit is set, the pointer moves forward by one after every access through the window, so a whole block of bytes can stream through the same register offset without reloading the pointer.

The register bus is 8 bits wide and uses separate read and write strobes. A read returns its data combinationally in the cycle the strobe is high. A window write takes effect on the clock edge that samples the strobe. The memory contents are not cleared by reset, because the storage is meant to keep its data. Only the pointer and the mode bit are reset.

Top module: `nvram_port`

## Requirements
- R1: After reset, the pointer register (offset 0x10) reads 0x00 and the mode register (offset 0x0F) reads 0x00.
- R2: A write to the data window (offset 0x13) stores the byte at the current pointer, and a later window read at that pointer returns it.
- R3: A write to the pointer register loads the pointer with the written byte on that edge. It changes no memory byte and causes no advance.
- R4: With the auto-advance bit set, a window write advances the pointer by one on the same edge that stores the byte.
- R5: With the auto-advance bit clear, window reads and writes leave the pointer unchanged, so repeated accesses touch the same byte.
- R6: Advancing from 0xFF wraps the pointer to 0x00.
- R7: A window read returns the byte at the current pointer during the strobe cycle. With auto-advance set, the pointer advances exactly once, on the first clock edge after the read strobe drops, however many cycles the strobe was held.
- R8: A read of the pointer register returns its current value, including any advance already applied.
- R9: The mode register keeps only bit 5, the auto-advance enable. A read of the mode register returns bit 5 and zeros in every other bit.
- R10: Reads of any other register offset return 0x00. Writes to other offsets change neither the pointer, nor the mode bit, nor the memory.
- R11: A pointer write on the same edge as a pending read advance takes precedence: the pointer takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the pointer and the mode bit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high, otherwise zero |

## Verification
The bench fills all 256 bytes in one auto-advance stream and reads each byte back singly. It also runs an auto-advance read sweep across the 0xFF to 0x00 boundary. A pointer that does not wrap, or that advances in the wrong mode, shows up as a mismatched byte or a wrong pointer readback. A read strobe held for several cycles must give exactly one step. A design that advances on every sampled strobe cycle, or at the start of the strobe, lands on the wrong byte. Writes to unmapped offsets, and a pointer load that collides with a pending read advance, are each checked against the pointer and memory state read back afterwards.

// File: rtl/nvp_pkg.sv
package nvp_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MODE = 2'd1,
    SEL_PTR  = 2'd2,
    SEL_WIN  = 2'd3
  } nvp_sel_e;

  localparam int NVP_REG_W = 5;

endpackage

// File: rtl/nvp_regdec.sv
module nvp_regdec
  import nvp_pkg::*;
#(
  parameter int                RW       = 5,
  parameter logic [RW-1:0]     OFF_MODE = 5'h0F,
  parameter logic [RW-1:0]     OFF_PTR  = 5'h10,
  parameter logic [RW-1:0]     OFF_WIN  = 5'h13
) (
  input  logic [RW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  output nvp_sel_e      sel,
  output logic          wr_mode,
  output logic          wr_ptr,
  output logic          wr_win,
  output logic          rd_win
);

  always_comb begin
    if (reg_addr == OFF_MODE)      sel = SEL_MODE;
    else if (reg_addr == OFF_PTR)  sel = SEL_PTR;
    else if (reg_addr == OFF_WIN)  sel = SEL_WIN;
    else                           sel = SEL_NONE;
  end

  assign wr_mode = reg_wr && (sel == SEL_MODE);
  assign wr_ptr  = reg_wr && (sel == SEL_PTR);
  assign wr_win  = reg_wr && (sel == SEL_WIN);
  assign rd_win  = reg_rd && (sel == SEL_WIN);

endmodule

// File: rtl/nvp_ptr.sv
module nvp_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv_en,
  input  logic          win_wr,
  input  logic          win_rd,
  output logic [AW-1:0] ptr,
  output logic          rd_end,
  output logic          step
);

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] cur);
    ptr_next = cur + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  logic rd_q;

  assign rd_end = rd_q && !win_rd;
  assign step   = adv_en && (win_wr || rd_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      ptr  <= '0;
    end else begin
      rd_q <= win_rd;
      if (load)      ptr <= load_val;
      else if (step) ptr <= ptr_next(ptr);
    end
  end

endmodule

// File: rtl/nvp_store.sv
module nvp_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/nvram_port.sv
module nvram_port
  import nvp_pkg::*;
#(
  parameter int            AW        = 8,
  parameter int            DW        = 8,
  parameter int            RW        = NVP_REG_W,
  parameter logic [RW-1:0] OFF_MODE  = 5'h0F,
  parameter logic [RW-1:0] OFF_PTR   = 5'h10,
  parameter logic [RW-1:0] OFF_WIN   = 5'h13,
  parameter int            BURST_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [RW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);

  nvp_sel_e      sel;
  logic          ev_mode_wr;
  logic          ev_addr_wr;
  logic          ev_win_wr;
  logic          ev_win_rd;
  logic          ev_rd_end;
  logic          ev_step;
  logic          burst_q;
  logic [AW-1:0] ptr_q;
  logic [DW-1:0] store_q;

  nvp_regdec #(
    .RW(RW), .OFF_MODE(OFF_MODE), .OFF_PTR(OFF_PTR), .OFF_WIN(OFF_WIN)
  ) u_dec (
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .sel      (sel),
    .wr_mode  (ev_mode_wr),
    .wr_ptr   (ev_addr_wr),
    .wr_win   (ev_win_wr),
    .rd_win   (ev_win_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          burst_q <= 1'b0;
    else if (ev_mode_wr) burst_q <= reg_wdata[BURST_BIT];
  end

  nvp_ptr #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_addr_wr),
    .load_val (reg_wdata[AW-1:0]),
    .adv_en   (burst_q),
    .win_wr   (ev_win_wr),
    .win_rd   (ev_win_rd),
    .ptr      (ptr_q),
    .rd_end   (ev_rd_end),
    .step     (ev_step)
  );

  nvp_store #(.AW(AW), .DW(DW)) u_store (
    .clk   (clk),
    .we    (ev_win_wr),
    .addr  (ptr_q),
    .wdata (reg_wdata),
    .rdata (store_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (sel)
        SEL_MODE: reg_rdata[BURST_BIT] = burst_q;
        SEL_PTR:  reg_rdata = DW'(ptr_q);
        SEL_WIN:  reg_rdata = store_q;
        default:  reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/nvram_port_chk.sv
module nvram_port_chk #(
  parameter int            AW        = 8,
  parameter int            DW        = 8,
  parameter int            RW        = 5,
  parameter logic [RW-1:0] OFF_MODE  = 5'h0F,
  parameter logic [RW-1:0] OFF_PTR   = 5'h10,
  parameter int            BURST_BIT = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [RW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic [AW-1:0] ptr_q,
  input logic          burst_q,
  input logic          ev_addr_wr,
  input logic          ev_step
);

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_wr |=> ptr_q == $past(reg_wdata[AW-1:0])); // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && !ev_addr_wr) |=> ptr_q == AW'($past(ptr_q) + 1'b1)); // R6

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_q && !ev_addr_wr) |=> $stable(ptr_q)); // R5

  AST_PTR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFF_PTR) |-> reg_rdata == DW'(ptr_q)); // R8

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_MODE) |=> burst_q == $past(reg_wdata[BURST_BIT])); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == '0); // R10

endmodule

bind nvram_port nvram_port_chk #(
  .AW(AW), .DW(DW), .RW(RW), .OFF_MODE(OFF_MODE), .OFF_PTR(OFF_PTR), .BURST_BIT(BURST_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .ptr_q      (ptr_q),
  .burst_q    (burst_q),
  .ev_addr_wr (ev_addr_wr),
  .ev_step    (ev_step)
);

// File: tb/nvram_port_bench.sv
module nvram_port_bench;

  localparam logic [4:0] O_MODE = 5'h0F;
  localparam logic [4:0] O_PTR  = 5'h10;
  localparam logic [4:0] O_WIN  = 5'h13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  nvram_port u_nvram_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] pat(input int i);
    pat = 8'((i * 37 + 5) % 256);
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] off, input logic [7:0] d);
    @(negedge clk);
    reg_addr = off; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] off, output logic [7:0] d);
    @(negedge clk);
    reg_addr = off; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got 0x00 expected 0x01");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    bus_rd(O_MODE, v); check("R1 mode", v, 8'h00);
    bus_rd(O_PTR,  v); check("R1 ptr",  v, 8'h00);

    bus_wr(O_MODE, 8'hFF); bus_rd(O_MODE, v); check("R9 mode bits", v, 8'h20);
    bus_wr(O_MODE, 8'hDF); bus_rd(O_MODE, v); check("R9 mode clear", v, 8'h00);

    // Stream fill with auto-advance
    bus_wr(O_MODE, 8'h20);
    bus_wr(O_PTR, 8'h00);
    for (int i = 0; i < 256; i++) begin
      bus_wr(O_WIN, pat(i));
      if (i == 2) begin bus_rd(O_PTR, v); check("R4 advance", v, 8'h03); end
    end
    bus_rd(O_PTR, v); check("R6 wrap after fill", v, 8'h00);

    // Single-byte readback with auto-advance off
    bus_wr(O_MODE, 8'h00);
    for (int i = 0; i < 256; i++) begin
      bus_wr(O_PTR, 8'(i));
      bus_rd(O_WIN, v); check("R2 R3 byte", v, pat(i));
      bus_rd(O_WIN, v); check("R5 repeat read", v, pat(i));
      bus_rd(O_PTR, v); check("R5 ptr held", v, 8'(i));
    end

    // Auto-advance read sweep across the wrap
    bus_wr(O_MODE, 8'h20);
    bus_wr(O_PTR, 8'hF0);
    for (int k = 0; k < 32; k++) begin
      bus_rd(O_WIN, v); check("R7 stream read", v, pat((240 + k) % 256));
      bus_rd(O_PTR, v); check("R8 R6 ptr", v, 8'((240 + k + 1) % 256));
    end

    // Repeated writes, auto-advance off
    bus_wr(O_MODE, 8'h00);
    bus_wr(O_PTR, 8'h40);
    bus_wr(O_WIN, 8'h11);
    bus_wr(O_WIN, 8'h22);
    bus_rd(O_PTR, v); check("R5 ptr after writes", v, 8'h40);
    bus_rd(O_WIN, v); check("R5 last write", v, 8'h22);
    bus_wr(O_PTR, 8'h41);
    bus_rd(O_WIN, v); check("R5 neighbour", v, pat(65));

    // Held read strobe: one advance only
    bus_wr(O_MODE, 8'h20);
    bus_wr(O_PTR, 8'h60);
    @(negedge clk);
    reg_addr = O_WIN; reg_rd = 1'b1;
    #1 check("R7 held data", reg_rdata, pat(96));
    repeat (3) @(negedge clk);
    #1 check("R7 held stable", reg_rdata, pat(96));
    reg_rd = 1'b0;
    @(negedge clk);
    bus_rd(O_PTR, v); check("R7 single step", v, 8'h61);

    // Unmapped offsets
    bus_wr(5'h05, 8'h77);
    bus_wr(5'h1F, 8'h00);
    bus_rd(5'h05, v); check("R10 unmapped read", v, 8'h00);
    bus_rd(O_PTR, v); check("R10 ptr kept", v, 8'h61);
    bus_rd(O_MODE, v); check("R10 mode kept", v, 8'h20);
    bus_wr(O_MODE, 8'h00);
    bus_rd(O_WIN, v); check("R10 byte kept", v, pat(97));

    // Pointer load colliding with pending read advance
    bus_wr(O_MODE, 8'h20);
    bus_wr(O_PTR, 8'h10);
    @(negedge clk);
    reg_addr = O_WIN; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = O_PTR; reg_wdata = 8'h33; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    bus_rd(O_PTR, v); check("R11 load wins", v, 8'h33);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule